// File: doc/BRIEF.md
# Host Receive Endpoint Control and Status

This block holds the 8-bit control and status byte for one receive endpoint of a USB host controller, together with an occupancy tracker for a two-slot receive packet buffer. Software reads the byte at any time and changes it with whole-byte writes. Each bit has its own access rule. Some bits set on a write of one. Some clear on a write of zero. Some are read-only and follow the buffer state.

A simplified transaction engine drives the event inputs. These report that a packet landed in the buffer, that a STALL handshake came back, that a NAK timeout or data error happened, or that the transfer failed. The block turns software writes into four outputs. It gives a one-cycle IN-request strobe, a one-cycle flush strobe that tells the buffer to drop its oldest packet, and the endpoint data toggle. It also gives an interrupt pulse when the stall or error status first becomes set.

Top module: `usb_rx_ep_ctl`

## Requirements
- R1: After a synchronous active-low reset, the status byte reads 0x00, the data toggle is 0, and the IN-request, interrupt and flush outputs are low.
- R2: The status byte uses fixed bit positions. Bit 6 is stalled, bit 5 is request-packet, bit 3 is NAK-timeout/data-error, bit 2 is error, bit 1 is buffer-full and bit 0 is packet-ready. Bits 7 and 4 are action bits and always read 0.
- R3: A write with bit 5 at 1 sets request-packet and raises the IN-request strobe for exactly the one cycle after the write. A write with bit 5 at 0 clears request-packet.
- R4: An accepted packet clears request-packet. If a write lands in the same cycle as the packet, the bit 5 value of that write wins.
- R5: Packet-ready is 1 while at least one slot holds a packet. Buffer-full is 1 while both slots do. A packet that arrives while the buffer is full is dropped. The data toggle inverts once for each accepted packet.
- R6: A write with bit 4 at 1 while packet-ready is set removes exactly one packet and pulses the flush output for the following cycle. A full buffer therefore needs two flushes to empty. A packet that arrives in the same cycle as a flush of a full buffer takes the freed slot.
- R7: A write with bit 4 at 1 while no packet is ready changes nothing and gives no flush pulse.
- R8: The STALL event sets bit 6, the error event sets bit 2 and the NAK/data-error event sets bit 3. The interrupt output is high for one cycle when bit 6 or bit 2 changes from 0 to 1. Bit 3 alone raises no interrupt.
- R9: Bits 6, 3 and 2 clear only when a write puts 0 in them, and a 1 written to them has no effect. Writes leave bits 1 and 0 unchanged.
- R10: When a hardware event and a zero write hit the same status bit in one cycle, the bit ends up set.
- R11: A write with bit 7 at 1 forces the data toggle to 0. This write wins over a flip from a packet accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Byte write strobe from the CPU side |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current status byte |
| ev_pkt_rcvd | input | 1 | A packet was received into the buffer |
| ev_stall | input | 1 | A STALL handshake was received |
| ev_nak_derr | input | 1 | NAK timeout or data error |
| ev_error | input | 1 | Transfer error or timeout |
| in_req_o | output | 1 | One-cycle IN-transaction request |
| data_tgl_o | output | 1 | Endpoint data toggle |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flush_o | output | 1 | One-cycle request to drop the oldest packet |

## Verification
The bench fills both slots and then sends a third packet. A design without the full check would overflow the count or flip the toggle on the lost packet. It flushes a full buffer twice and then an empty one. A wrong design would leave a packet behind, send a flush pulse for nothing, or wrap the count below zero. It also sends an event in the same cycle as a clearing write, a toggle clear together with a packet, and a request write together with a packet. Each of these shows whether the right side wins. Writing all ones while stalled catches a design that treats bit 6 as write-one-to-clear, or that lets the action bits read back as 1.

// File: rtl/rxep_pkg.sv
// Package: rxep_pkg
// Bit positions of the endpoint status byte, shared by the design and the checker.
// Assumes an 8-bit register; the positions are decoded by software.
package rxep_pkg;
    localparam int REG_W      = 8;
    localparam int B_CLRTGL   = 7;
    localparam int B_STALLED  = 6;
    localparam int B_REQ      = 5;
    localparam int B_FLUSH    = 4;
    localparam int B_NAKDERR  = 3;
    localparam int B_ERROR    = 2;
    localparam int B_FULL     = 1;
    localparam int B_READY    = 0;
    localparam int NUM_FLAGS  = 3;
    // flag vector index order: 0 = stalled, 1 = nak/data-error, 2 = error
    localparam int F_STALL    = 0;
    localparam int F_NAK      = 1;
    localparam int F_ERR      = 2;
endpackage

// File: rtl/rxep_occupancy.sv
// Module: rxep_occupancy
// Counts the packets held in a SLOTS-deep receive buffer.
// Assumes one push and at most one pop per cycle. A push into a full buffer
// is dropped unless a pop frees a slot in the same cycle. A pop of an empty
// buffer is ignored.
module rxep_occupancy #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop_req,
    output logic ready,
    output logic full,
    output logic accepted,
    output logic popped
);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(SLOTS);

    logic [CNT_W-1:0] cnt_q;

    // pop and push qualification against the current count
    always_comb begin
        popped   = pop_req && (cnt_q != '0);
        accepted = push && ((cnt_q != MAX_CNT) || popped);
        ready    = (cnt_q != '0);
        full     = (cnt_q == MAX_CNT);
    end

    // occupancy counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accepted && !popped) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (popped && !accepted) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/rxep_flags.sv
// Module: rxep_flags
// A bank of NUM sticky status flags. Each flag is set by a hardware event
// and is cleared by a software write of 0 to its bit. A write of 1 does nothing.
// Assumes that a set event and a clear in the same cycle leave the flag set.
module rxep_flags #(
    parameter int NUM = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_ev,
    input  logic           wr,
    input  logic [NUM-1:0] wbits,
    output logic [NUM-1:0] q
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        logic f_q;
        // one sticky flag: set has priority over a zero write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
            end else if (set_ev[i]) begin
                f_q <= 1'b1;
            end else if (wr && !wbits[i]) begin
                f_q <= 1'b0;
            end
        end
        assign q[i] = f_q;
    end
endmodule

// File: rtl/rxep_toggle.sv
// Module: rxep_toggle
// Endpoint data toggle. It inverts for each accepted packet and is forced to 0
// on request. Assumes that the clear wins over a flip in the same cycle.
module rxep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic flip,
    output logic tgl
);
    logic tgl_q;

    // toggle state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (clr) begin
            tgl_q <= 1'b0;
        end else if (flip) begin
            tgl_q <= ~tgl_q;
        end
    end
    assign tgl = tgl_q;
endmodule

// File: rtl/usb_rx_ep_ctl.sv
// Module: usb_rx_ep_ctl
// Control and status byte for one host receive endpoint, with double-buffer
// occupancy tracking. Reads return the byte combinationally from registers.
// Writes are whole-byte writes, and each bit follows its own access rule.
// Assumes a synchronous active-low reset and one write per cycle at most.
module usb_rx_ep_ctl #(
    parameter int SLOTS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_pkt_rcvd,
    input  logic       ev_stall,
    input  logic       ev_nak_derr,
    input  logic       ev_error,
    output logic       in_req_o,
    output logic       data_tgl_o,
    output logic       irq_o,
    output logic       flush_o
);
    import rxep_pkg::*;

    logic                 ready, full, accepted, popped;
    logic                 flush_wr, clrtgl_wr;
    logic                 req_q, in_req_q, flush_q;
    logic [NUM_FLAGS-1:0] flag_set, flag_wbits, flag_q, flag_prev_q;
    logic [NUM_FLAGS-1:0] irq_mask;

    // decode of the action bits in a write
    always_comb begin
        flush_wr  = reg_wr && reg_wdata[B_FLUSH];
        clrtgl_wr = reg_wr && reg_wdata[B_CLRTGL];
    end

    rxep_occupancy #(.SLOTS(SLOTS)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ev_pkt_rcvd),
        .pop_req  (flush_wr),
        .ready    (ready),
        .full     (full),
        .accepted (accepted),
        .popped   (popped)
    );

    // route the events and the write bits to the sticky flag bank
    always_comb begin
        flag_set            = '0;
        flag_set[F_STALL]   = ev_stall;
        flag_set[F_NAK]     = ev_nak_derr;
        flag_set[F_ERR]     = ev_error;
        flag_wbits          = '0;
        flag_wbits[F_STALL] = reg_wdata[B_STALLED];
        flag_wbits[F_NAK]   = reg_wdata[B_NAKDERR];
        flag_wbits[F_ERR]   = reg_wdata[B_ERROR];
        irq_mask            = '0;
        irq_mask[F_STALL]   = 1'b1;
        irq_mask[F_ERR]     = 1'b1;
    end

    rxep_flags #(.NUM(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (flag_set),
        .wr     (reg_wr),
        .wbits  (flag_wbits),
        .q      (flag_q)
    );

    rxep_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clrtgl_wr),
        .flip  (accepted),
        .tgl   (data_tgl_o)
    );

    // request bit: the write value wins, otherwise a packet clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (reg_wr) begin
            req_q <= reg_wdata[B_REQ];
        end else if (accepted) begin
            req_q <= 1'b0;
        end
    end

    // one-cycle output strobes and the previous flag state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_req_q    <= 1'b0;
            flush_q     <= 1'b0;
            flag_prev_q <= '0;
        end else begin
            in_req_q    <= reg_wr && reg_wdata[B_REQ];
            flush_q     <= popped;
            flag_prev_q <= flag_q;
        end
    end

    // output assembly and status byte readout
    always_comb begin
        in_req_o              = in_req_q;
        flush_o               = flush_q;
        irq_o                 = |(flag_q & ~flag_prev_q & irq_mask);
        reg_rdata             = '0;
        reg_rdata[B_STALLED]  = flag_q[F_STALL];
        reg_rdata[B_REQ]      = req_q;
        reg_rdata[B_NAKDERR]  = flag_q[F_NAK];
        reg_rdata[B_ERROR]    = flag_q[F_ERR];
        reg_rdata[B_FULL]     = full;
        reg_rdata[B_READY]    = ready;
    end
endmodule

// File: rtl/rxep_checker.sv
// Module: rxep_checker
// Port-level properties of usb_rx_ep_ctl. It is attached to the top module
// with a bind statement.
module rxep_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       ev_pkt_rcvd,
    input logic       ev_stall,
    input logic       ev_error,
    input logic       in_req_o,
    input logic       data_tgl_o,
    input logic       irq_o,
    input logic       flush_o
);
    AST_ACTION_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[7] == 1'b0) && (reg_rdata[4] == 1'b0)); // R2
    AST_STROBE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        in_req_o |-> reg_rdata[5]); // R3
    AST_PKT_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pkt_rcvd && !reg_rdata[1] && !reg_wr) |=> !reg_rdata[5]); // R4
    AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |-> reg_rdata[0]); // R5
    AST_FLUSH_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $past(reg_rdata[0])); // R7
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((reg_rdata[6] && !$past(reg_rdata[6])) ||
                   (reg_rdata[2] && !$past(reg_rdata[2])))); // R8
    AST_W1_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[6] && reg_rdata[6]) |=> reg_rdata[6]); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stall || ev_error) |=> (reg_rdata[6] || reg_rdata[2])); // R10
    AST_TGL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[7]) |=> !data_tgl_o); // R11
endmodule

bind usb_rx_ep_ctl rxep_checker u_rxep_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .ev_pkt_rcvd (ev_pkt_rcvd),
    .ev_stall    (ev_stall),
    .ev_error    (ev_error),
    .in_req_o    (in_req_o),
    .data_tgl_o  (data_tgl_o),
    .irq_o       (irq_o),
    .flush_o     (flush_o)
);

// File: tb/usb_rx_ep_ctl_bench.sv
// Scoreboard bench. The driver task applies one cycle of stimulus and pushes
// the outputs expected after that edge. The monitor pops and compares 1 ns
// after each rising edge.
module usb_rx_ep_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_pkt_rcvd = 1'b0, ev_stall = 1'b0, ev_nak_derr = 1'b0, ev_error = 1'b0;
    logic       in_req_o, data_tgl_o, irq_o, flush_o;

    typedef struct {
        logic [7:0] rd;
        logic       tgl, inreq, irq, flush;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    usb_rx_ep_ctl u_usb_rx_ep_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ev_pkt_rcvd(ev_pkt_rcvd), .ev_stall(ev_stall),
        .ev_nak_derr(ev_nak_derr), .ev_error(ev_error), .in_req_o(in_req_o),
        .data_tgl_o(data_tgl_o), .irq_o(irq_o), .flush_o(flush_o)
    );

    task automatic compare(input exp_t e);
        n_checks++;
        if (reg_rdata !== e.rd || data_tgl_o !== e.tgl || in_req_o !== e.inreq ||
            irq_o !== e.irq || flush_o !== e.flush) begin
            n_fail++;
            $display("FAIL %s: got rd=%h tgl=%b req=%b irq=%b fl=%b, expected rd=%h tgl=%b req=%b irq=%b fl=%b",
                     e.tag, reg_rdata, data_tgl_o, in_req_o, irq_o, flush_o,
                     e.rd, e.tgl, e.inreq, e.irq, e.flush);
        end
    endtask

    // driver: one cycle of stimulus plus the expected result after the edge
    task automatic step(input logic wr, input logic [7:0] wd, input logic pkt,
                        input logic stl, input logic nak, input logic err,
                        input logic [7:0] rd, input logic tgl, input logic inreq,
                        input logic irq, input logic fl, input string tag);
        exp_t e;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; ev_pkt_rcvd = pkt;
        ev_stall = stl; ev_nak_derr = nak; ev_error = err;
        e.rd = rd; e.tgl = tgl; e.inreq = inreq; e.irq = irq; e.flush = fl; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare after each edge that has an expected item pending
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        exp_t e0;
        repeat (3) @(posedge clk);
        #1;
        e0.rd = 8'h00; e0.tgl = 1'b0; e0.inreq = 1'b0; e0.irq = 1'b0; e0.flush = 1'b0;
        e0.tag = "R1 reset state";
        compare(e0);
        @(negedge clk);
        rst_n = 1'b1;
        //   wr  wdata  pkt stl nak err   rd    tgl req irq fl
        step(1, 8'h20, 0, 0, 0, 0, 8'h20, 0, 1, 0, 0, "R3 request sets bit and strobes");
        step(0, 8'h00, 0, 0, 0, 0, 8'h20, 0, 0, 0, 0, "R3 strobe lasts one cycle");
        step(0, 8'h00, 1, 0, 0, 0, 8'h01, 1, 0, 0, 0, "R4 packet clears request, R5 ready");
        step(0, 8'h00, 1, 0, 0, 0, 8'h03, 0, 0, 0, 0, "R5 second packet sets full");
        step(0, 8'h00, 1, 0, 0, 0, 8'h03, 0, 0, 0, 0, "R5 packet dropped when full");
        step(1, 8'h10, 0, 0, 0, 0, 8'h01, 0, 0, 0, 1, "R6 first flush removes one");
        step(1, 8'h10, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1, "R6 second flush empties");
        step(1, 8'h10, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R7 flush on empty ignored");
        step(0, 8'h00, 0, 1, 0, 0, 8'h40, 0, 0, 1, 0, "R8 stall sets bit and interrupts");
        step(1, 8'hFF, 0, 0, 0, 0, 8'h60, 0, 1, 0, 0, "R9 ones leave stalled, R2 action bits read 0");
        step(1, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R9 zero write clears stalled");
        step(0, 8'h00, 0, 0, 1, 1, 8'h0C, 0, 0, 1, 0, "R8 error and nak set");
        step(1, 8'h08, 0, 0, 0, 1, 8'h0C, 0, 0, 0, 0, "R10 set wins over clear");
        step(1, 8'h00, 0, 0, 0, 0, 8'h00, 0, 0, 0, 0, "R9 zero write clears nak and error");
        step(0, 8'h00, 0, 0, 1, 0, 8'h08, 0, 0, 0, 0, "R8 nak alone raises no interrupt");
        step(1, 8'h00, 1, 0, 0, 0, 8'h01, 1, 0, 0, 0, "R5 toggle flips on packet");
        step(1, 8'h80, 1, 0, 0, 0, 8'h03, 0, 0, 0, 0, "R11 toggle clear beats flip");
        step(1, 8'h10, 1, 0, 0, 0, 8'h03, 1, 0, 0, 1, "R6 flush at full with packet");
        step(1, 8'h10, 0, 0, 0, 0, 8'h01, 1, 0, 0, 1, "R6 flush leaves one");
        step(1, 8'h20, 1, 0, 0, 0, 8'h23, 0, 1, 0, 0, "R4 write wins over packet clear");
        step(1, 8'h00, 0, 1, 0, 0, 8'h43, 0, 0, 1, 0, "R10 stall beats zero write");
        step(0, 8'h00, 0, 0, 0, 0, 8'h43, 0, 0, 0, 0, "R8 interrupt is one cycle");
        @(negedge clk);
        reg_wr = 1'b0; ev_stall = 1'b0; ev_pkt_rcvd = 1'b0;
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule